// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block guards a system against a stalled program. A free-running prescaler divides a selectable count clock, and one of its taps decrements a down-counter. Software must keep restarting the counter with a two-write key sequence. If the counter runs out while the watchdog is in reset mode, the block pulses a reset request for the system reset tree. If it runs out in interval mode, a timeout flag is set and an interrupt is raised, so the block can serve as a periodic timer.

Software reaches the block through a small byte-wide register port with four addresses. Address 0 is control, address 1 is the reload value, and addresses 2 and 3 are the two key registers. The key sequence is checked strictly. In reset mode, a wrong key value, a key out of order, any other access between the two keys, or a control write that is not followed at once by a key sequence each request a reset. The count clock comes either from the peripheral clock, which stops during power-down, or from a slow-oscillator enable pulse.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset (rst_n low), wdt_rst_o and irq_o are 0. The control register reads 0x00 and address 2 reads the counter as all ones.
- R2: A valid feed is a write of 0xA5 to address 2, and the very next bus access must be a write of 0x5A to address 3. At that second write the counter loads the reload register (address 1) and the prescaler clears. With the counter running, the underflow then comes (reload+1)·2^(PRE_W−TAP_N+1+sel) enabled count cycles after the feed.
- R3: Control bits [5:3] select the prescaler tap, and tap sel doubles the tick interval once per step.
- R4: In reset mode (control bit 6 = 1), a tick with the counter at 0 makes wdt_rst_o high for exactly the next cycle and sets the timeout flag (control bit 1).
- R5: In reset mode, a write of a value other than 0xA5 to address 2 requests a reset in the cycle after the write. So does a write to address 3 that does not directly follow a correct address-2 key, and so does a wrong value written to address 3.
- R6: In reset mode, any bus read or write after a correct address-2 key, other than the address-3 key, aborts the sequence and requests a reset.
- R7: In reset mode, a control write whose next bus access does not begin a valid feed requests a reset. A control write followed by a valid feed requests none.
- R8: In interval mode (control bit 6 = 0), underflow sets the timeout flag and irq_o follows that flag. Neither underflow nor a bad feed ever raises wdt_rst_o.
- R9: At underflow the counter reloads from a shadow copy of the reload value, taken at the last valid feed. Writes to address 1 after that feed do not change the auto-reload value.
- R10: Writing 0 to control bit 1 clears the timeout flag. Writing 1 leaves it unchanged.
- R11: Control bit 6 can be set by a write but not cleared by one. Only rst_n clears it.
- R12: Control bit 2 = 0 selects the peripheral clock, which advances the prescaler on every cycle without pwr_down_i. Bit 2 = 1 advances the prescaler only on cycles with slow_ce_i high, whatever pwr_down_i is.
- R13: With control bit 0 = 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (address 2 returns the counter) |
| slow_ce_i | input | 1 | Slow-oscillator clock enable pulse |
| pwr_down_i | input | 1 | Power-down indication |
| wdt_rst_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interval-timer interrupt |

## Verification
The bench builds the block with PRE_W = 4 and TAP_N = 4 and keeps the counter at 8 bits. The four taps then divide by 2, 4, 8 and 16. This puts the underflow of every tap, including the one that spans the whole prescaler, within a few dozen cycles, so each timeout period can be measured to the exact cycle. The same short periods let the bench reach both modes, the shadow reload, power-down gating and the slow enable within a brief run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_RELOAD = 2'd1;
    localparam logic [1:0] ADR_KEY1   = 2'd2;
    localparam logic [1:0] ADR_KEY2   = 2'd3;

    localparam logic [7:0] KEY1_VAL = 8'hA5;
    localparam logic [7:0] KEY2_VAL = 8'h5A;

    localparam int B_RUN   = 0;
    localparam int B_FLAG  = 1;
    localparam int B_SRC   = 2;
    localparam int B_SEL   = 3;
    localparam int B_WDMOD = 6;

    typedef struct packed {
        logic armed;   // correct first key seen
        logic pend;    // control written, feed must follow
    } feed_st_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W = 12,
    parameter int TAP_N = 8,
    localparam int SEL_W = (TAP_N > 1) ? $clog2(TAP_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] tap_mask [TAP_N];

    // Tap g spans the low PRE_W-TAP_N+1+g prescaler bits.
    for (genvar g = 0; g < TAP_N; g++) begin : g_tap
        assign tap_mask[g] = {PRE_W{1'b1}} >> (TAP_N - 1 - g);
    end

    always_comb begin
        pre_d = pre_q;
        if (clr_i)      pre_d = '0;
        else if (adv_i) pre_d = pre_q + 1'b1;
    end

    assign tick_o = adv_i && ((pre_q & tap_mask[sel_i]) == tap_mask[sel_i]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R12
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_feed.sv
module wdt_feed
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic       feed_ok_o,
    output logic       feed_bad_o
);
    feed_st_t st_d, st_q;
    logic acc, wr_k1, wr_k2, wr_ctl;

    always_comb begin
        acc    = wr_en_i || rd_en_i;
        wr_k1  = wr_en_i && (addr_i == ADR_KEY1);
        wr_k2  = wr_en_i && (addr_i == ADR_KEY2);
        wr_ctl = wr_en_i && (addr_i == ADR_CTRL);
        st_d       = st_q;
        feed_ok_o  = 1'b0;
        feed_bad_o = 1'b0;
        if (acc) begin
            if (st_q.armed) begin
                st_d = '0;
                if (wr_k2 && wdata_i == KEY2_VAL) feed_ok_o  = 1'b1;
                else                              feed_bad_o = 1'b1;
            end else if (wr_k1) begin
                st_d.pend = 1'b0;
                if (wdata_i == KEY1_VAL) st_d.armed = 1'b1;
                else                     feed_bad_o = 1'b1;
            end else if (st_q.pend) begin
                feed_bad_o = 1'b1;
                st_d.pend  = wr_ctl;
            end else if (wr_k2) begin
                feed_bad_o = 1'b1;
            end else if (wr_ctl) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    ok_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok_o |=> !st_q.armed);
    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(feed_ok_o && feed_bad_o));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int TAP_N = 8,
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       slow_ce_i,
    input  logic       pwr_down_i,
    output logic       wdt_rst_o,
    output logic       irq_o
);
    localparam int SEL_W = (TAP_N > 1) ? $clog2(TAP_N) : 1;

    typedef struct packed {
        logic             run;
        logic             tflag;
        logic             src;
        logic [2:0]       sel;
        logic             wdmod;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } wd_st_t;

    wd_st_t s_d, s_q;
    logic adv, tick, feed_ok, feed_bad, uflow;

    wdt_feed i_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .feed_ok_o (feed_ok),
        .feed_bad_o(feed_bad)
    );

    assign adv = s_q.src ? slow_ce_i : !pwr_down_i;

    wdt_prescaler #(.PRE_W(PRE_W), .TAP_N(TAP_N)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (adv),
        .clr_i (feed_ok),
        .sel_i (s_q.sel[SEL_W-1:0]),
        .tick_o(tick)
    );

    always_comb begin
        s_d   = s_q;
        s_d.rst = 1'b0;
        uflow = 1'b0;
        if (wr_en_i && addr_i == ADR_CTRL) begin
            s_d.run   = wdata_i[B_RUN];
            s_d.src   = wdata_i[B_SRC];
            s_d.sel   = wdata_i[B_SEL +: 3];
            s_d.wdmod = s_q.wdmod | wdata_i[B_WDMOD];
            if (!wdata_i[B_FLAG]) s_d.tflag = 1'b0;
        end
        if (wr_en_i && addr_i == ADR_RELOAD)
            s_d.reload = wdata_i[CNT_W-1:0];
        if (feed_ok) begin
            s_d.cnt    = s_q.reload;
            s_d.shadow = s_q.reload;
        end else if (s_q.run && tick) begin
            if (s_q.cnt == '0) begin
                uflow     = 1'b1;
                s_d.cnt   = s_q.shadow;
                s_d.tflag = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (s_q.wdmod && (uflow || feed_bad)) s_d.rst = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wdt_rst_o = s_q.rst;
    assign irq_o     = s_q.tflag && !s_q.wdmod;

    always_comb begin
        case (addr_i)
            ADR_CTRL:   rdata_o = {1'b0, s_q.wdmod, s_q.sel, s_q.src, s_q.tflag, s_q.run};
            ADR_RELOAD: rdata_o = 8'(s_q.reload);
            ADR_KEY1:   rdata_o = 8'(s_q.cnt);
            default:    rdata_o = 8'h00;
        endcase
    end

    // R8
    timer_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.wdmod |=> !wdt_rst_o);
    // R11
    wdmod_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wdmod |=> s_q.wdmod);
    // R2
    feed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (s_q.cnt == $past(s_q.reload)));
    // R13
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !feed_ok) |=> $stable(s_q.cnt));
    // R4
    uf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && tick && s_q.cnt == '0 && !feed_ok) |=> s_q.tflag);
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       slow_ce = 1'b0, pwr_down = 1'b0;
    logic       wdt_rst, irq;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wdt_keyed #(.PRE_W(4), .TAP_N(4), .CNT_W(8)) i_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .slow_ce_i(slow_ce), .pwr_down_i(pwr_down),
        .wdt_rst_o(wdt_rst), .irq_o(irq)
    );

    // {sel, reload, expected cycles from feed to reset pulse}
    localparam logic [19:0] VEC [5] = '{
        {4'd0, 8'd0, 8'd2},  {4'd0, 8'd3, 8'd8},  {4'd1, 8'd2, 8'd12},
        {4'd3, 8'd1, 8'd32}, {4'd2, 8'd5, 8'd48}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h5A);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        bit saw;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 rst", wdt_rst, 0);
        check("R1 irq", irq, 0);
        peek(2'd0, v); check("R1 ctrl", v, 8'h00);
        peek(2'd2, v); check("R1 cnt", v, 8'hFF);

        // R13 / R2: stopped counter loads on feed and holds
        wr(2'd1, 8'd2); wr(2'd0, 8'h00); feed();
        peek(2'd2, v); check("R2 load", v, 2);
        cyc(20);
        peek(2'd2, v); check("R13 hold", v, 2);

        // R8 / R9: interval mode, shadow reload
        wr(2'd0, 8'h01); feed();
        wr(2'd1, 8'd9);
        n = 0; saw = 1'b0;
        while (!irq && n < 100) begin @(posedge clk); #1 n++; if (wdt_rst) saw = 1'b1; end
        check("R8 irq", irq, 1);
        check("R8 no rst", saw, 0);
        peek(2'd2, v); check("R9 shadow", v, 2);
        peek(2'd0, v); check("R8 flag", v[1], 1);
        wr(2'd3, 8'h5A); check("R8 badfeed no rst", wdt_rst, 0);

        // R10 flag write 1 keeps, write 0 clears
        wr(2'd0, 8'h02);
        peek(2'd0, v); check("R10 keep", v[1], 1);
        wr(2'd0, 8'h00);
        peek(2'd0, v); check("R10 clear", v[1], 0);
        check("R10 irq low", irq, 0);

        // R12 power-down stops peripheral-clock counting
        wr(2'd1, 8'd5); wr(2'd0, 8'h01); feed();
        @(negedge clk) pwr_down = 1'b1;
        peek(2'd2, v); cyc(10); peek(2'd2, v2);
        check("R12 pd hold", v2, v);
        // R12 slow enable drives the prescaler regardless of pwr_down
        wr(2'd0, 8'h05); feed();
        cyc(10);
        peek(2'd2, v); check("R12 slow idle", v, 5);
        @(negedge clk) slow_ce = 1'b1;
        @(negedge clk); @(negedge clk) slow_ce = 1'b0;
        peek(2'd2, v); check("R12 slow tick", v, 4);
        @(negedge clk) pwr_down = 1'b0;

        // R2 R3 R4: timeout period per tap in reset mode
        for (int k = 0; k < 5; k++) begin
            wr(2'd1, VEC[k][15:8]);
            wr(2'd0, 8'h41 | {2'b00, VEC[k][18:16], 3'b000});
            feed();
            n = 0;
            while (!wdt_rst && n < 400) begin @(posedge clk); #1 n++; end
            check("R2 R3 period", n, int'(VEC[k][7:0]));
            @(posedge clk); #1 check("R4 pulse width", wdt_rst, 0);
            peek(2'd0, v); check("R4 flag", v[1], 1);
        end

        // stop counter, stay in reset mode
        wr(2'd0, 8'h40); feed();
        check("R7 ctrl+feed no rst", wdt_rst, 0);
        cyc(2);

        // R5 bad keys
        wr(2'd2, 8'h12); check("R5 bad key1", wdt_rst, 1);
        cyc(1); check("R5 pulse end", wdt_rst, 0);
        wr(2'd3, 8'h5A); check("R5 key2 alone", wdt_rst, 1);
        cyc(1);
        wr(2'd2, 8'hA5); check("R5 key1 ok", wdt_rst, 0);
        wr(2'd3, 8'h55); check("R5 bad key2", wdt_rst, 1);
        cyc(1);

        // R6 other access between keys
        wr(2'd2, 8'hA5); rd(2'd1); check("R6 read between", wdt_rst, 1);
        cyc(1);
        wr(2'd2, 8'hA5); wr(2'd1, 8'd7); check("R6 write between", wdt_rst, 1);
        cyc(1);

        // R7 control write not followed by feed
        wr(2'd0, 8'h40); check("R7 ctrl alone", wdt_rst, 0);
        wr(2'd1, 8'd3);  check("R7 no feed", wdt_rst, 1);
        cyc(1);

        // R11 mode bit cannot be cleared by write
        wr(2'd0, 8'h00); feed();
        peek(2'd0, v); check("R11 sticky", v[6], 1);
        wr(2'd3, 8'h5A); check("R11 still reset mode", wdt_rst, 1);
        cyc(1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        peek(2'd0, v); check("R11 por clears", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule